// File: doc/BRIEF.md
# Cipher Engine Status and Key-Load Tracker

This block is the status side of a memory-mapped block-cipher peripheral. It sits beside the cipher datapath and watches software's accesses to the data-input port and the data-output port. It also runs a phase machine that steps through four states: idle, input, computation and output. An access that arrives in the wrong phase is not passed on. A wrong-phase write is dropped and a wrong-phase read returns zero. In both cases a sticky error flag is raised, and an interrupt request follows when it is enabled. The cipher operation itself carries on unchanged.

The block also checks that the key registers are loaded correctly before the engine may be enabled. Key words must be written from the highest index down to index 0. The number of words depends on a key-size selector. A write out of order latches a key error that software must clear. When the key-select field is nonzero, the key comes from a hardware source instead. The block then shows busy while it waits for that source's done/ok handshake. The datapath and the hardware key source are external; they appear here only as handshake inputs.

Phase states: `PH_IDLE`, `PH_LOAD` (input), `PH_CRUNCH` (computation), `PH_DRAIN` (output). Phase transitions:
- IDLE to LOAD when enabled.
- LOAD to CRUNCH on the last input word.
- CRUNCH to DRAIN on `core_done`.
- DRAIN to LOAD on the last output read.
- Any state to IDLE when disabled.

Key states: `KS_EMPTY`, `KS_COLLECT`, `KS_HWLOAD`, `KS_READY`, `KS_FAULT`. Key transitions:
- EMPTY to HWLOAD when the key select is nonzero.
- EMPTY, COLLECT or READY to COLLECT on a correct software word.
- EMPTY, COLLECT or READY to READY on the final correct word.
- EMPTY, COLLECT or READY to FAULT on a wrong word index.
- HWLOAD to READY or FAULT on `hw_key_done`.
- FAULT to EMPTY on `keyerr_clr`.
- Any state except FAULT to EMPTY when the key size or key select changes.

Top module: `cipher_status_tracker`

## Requirements
- R1: After reset, `en`, `busy`, `ccf`, `wrerr`, `rderr`, `keyvalid`, `keyerr` and `irq` are all 0.
- R2: A `din_wr` in the computation or output phase is not forwarded. `din_fwd` stays 0 and `din_fdata` stays 0. `wrerr` is 1 from the next cycle on.
- R3: A `dout_rd` in the input or computation phase returns `dout_rdata` = 0 in the same cycle, and `rderr` is 1 from the next cycle on.
- R4: A wrong-phase access changes neither the phase nor the word count. A stray read in the input phase still leaves 4 writes needed to reach computation, and a stray write during computation keeps `busy` at 1.
- R5: A pulse on `rwe_clr` clears both `wrerr` and `rderr` on the next cycle, provided no port access occurs in that same cycle.
- R6: `irq` is 1 exactly while `rwe_ie` is 1 and at least one of `wrerr` or `rderr` is 1.
- R7: `key_size`=0 needs 4 key words and `key_size`=1 needs 8. The words must be written with `key_idx` running from the top index down to 0, one per `key_wr` cycle. `keyvalid` is 1 from the cycle after the final word. A partial sequence leaves it 0.
- R8: A `key_wr` whose `key_idx` is not the next expected index sets `keyerr` to 1 on the next cycle and leaves `keyvalid` at 0.
- R9: While `keyerr` is 1 it stays 1, key writes are ignored and `keyvalid` stays 0. A `keyerr_clr` pulse returns the tracker to empty.
- R10: With `key_sel` nonzero, `busy` is 1 from the second cycle after the selection until `hw_key_done`. Then `hw_key_ok`=1 gives `keyvalid`=1 and `busy`=0, while `hw_key_ok`=0 gives `keyerr`=1, `busy`=0 and `keyvalid`=0.
- R11: `en_set` has no effect while `keyvalid` is 0; with `keyvalid`=1 it sets `en` on the next cycle.
- R12: The phase sequence runs input (4 forwarded writes), then computation, then output. `core_done` during computation sets `ccf` and starts output, where `dout_rdata` = `core_dout`. After 4 reads the phase returns to input. `ccf_clr` clears `ccf`.
- R13: A change of `key_size` or `key_sel` clears `keyvalid` on the next cycle and restarts the word sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_set | input | 1 | Software request to set enable |
| en_clr | input | 1 | Software request to clear enable |
| din_wr | input | 1 | Write strobe to data-input port |
| din_wdata | input | DW | Write data |
| din_fwd | output | 1 | Write forwarded to datapath |
| din_fdata | output | DW | Forwarded data (0 when dropped) |
| dout_rd | input | 1 | Read strobe on data-output port |
| core_dout | input | DW | Datapath output word |
| dout_rdata | output | DW | Read data returned to software |
| core_done | input | 1 | Datapath finished a block |
| key_size | input | 1 | 0: 4-word key, 1: 8-word key |
| key_sel | input | 2 | 0: software key, nonzero: hardware key source |
| key_wr | input | 1 | Key register write strobe |
| key_idx | input | 3 | Index of key word written |
| hw_key_done | input | 1 | Hardware key source finished |
| hw_key_ok | input | 1 | Hardware key load succeeded |
| keyerr_clr | input | 1 | Clear key error |
| rwe_clr | input | 1 | Clear both access-error flags |
| ccf_clr | input | 1 | Clear completion flag |
| rwe_ie | input | 1 | Access-error interrupt enable |
| en | output | 1 | Engine enabled |
| busy | output | 1 | Computation or hardware key load in progress |
| ccf | output | 1 | Computation complete |
| wrerr | output | 1 | Wrong-phase write seen |
| rderr | output | 1 | Wrong-phase read seen |
| keyvalid | output | 1 | Valid key loaded |
| keyerr | output | 1 | Key load error latched |
| irq | output | 1 | Interrupt request |

## Verification
The key tracker is driven from a table of index sequences:
- complete descending runs for both key sizes;
- a run that skips an index;
- a run that starts at the short-key top while the long key is selected;
- an ascending run;
- a truncated run.

These patterns separate the cases where the length check, the ordering check, the start-index check and the completion check are each at fault. Directed phases then place stray reads in the input phase and stray writes during computation. They show that such accesses are flagged but neither counted nor forwarded. Further directed tests cover the hardware key path in both its fail and succeed outcomes, and show that key errors persist until cleared.

// File: rtl/cst_pkg.sv
package cst_pkg;
    typedef enum logic [1:0] {
        PH_IDLE,
        PH_LOAD,
        PH_CRUNCH,
        PH_DRAIN
    } phase_e;

    typedef enum logic [2:0] {
        KS_EMPTY,
        KS_COLLECT,
        KS_HWLOAD,
        KS_READY,
        KS_FAULT
    } kstate_e;
endpackage

// File: rtl/cst_phase_ctrl.sv
module cst_phase_ctrl
    import cst_pkg::*;
#(
    parameter int BLK_WORDS = 4
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   en_set,
    input  logic   en_clr,
    input  logic   keyvalid,
    input  logic   din_wr,
    input  logic   dout_rd,
    input  logic   core_done,
    input  logic   ccf_clr,
    output logic   en,
    output phase_e phase,
    output logic   ccf
);
    localparam int BCW = (BLK_WORDS > 1) ? $clog2(BLK_WORDS) : 1;
    localparam logic [BCW-1:0] LAST = BCW'(BLK_WORDS - 1);

    phase_e         ph_q, ph_d;
    logic [BCW-1:0] wc_q, wc_d;
    logic           en_q, ccf_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q  <= PH_IDLE;
            wc_q  <= '0;
            en_q  <= 1'b0;
            ccf_q <= 1'b0;
        end else begin
            ph_q <= ph_d;
            wc_q <= wc_d;
            if (en_clr)
                en_q <= 1'b0;
            else if (en_set && keyvalid)
                en_q <= 1'b1;
            if (core_done && ph_q == PH_CRUNCH)
                ccf_q <= 1'b1;
            else if (ccf_clr)
                ccf_q <= 1'b0;
        end
    end

    // next state
    always_comb begin
        ph_d = ph_q;
        wc_d = wc_q;
        if (!en_q) begin
            ph_d = PH_IDLE;
            wc_d = '0;
        end else begin
            unique case (ph_q)
                PH_IDLE: ph_d = PH_LOAD;
                PH_LOAD:
                    if (din_wr) begin
                        if (wc_q == LAST) begin
                            ph_d = PH_CRUNCH;
                            wc_d = '0;
                        end else begin
                            wc_d = wc_q + 1'b1;
                        end
                    end
                PH_CRUNCH:
                    if (core_done) ph_d = PH_DRAIN;
                PH_DRAIN:
                    if (dout_rd) begin
                        if (wc_q == LAST) begin
                            ph_d = PH_LOAD;
                            wc_d = '0;
                        end else begin
                            wc_d = wc_q + 1'b1;
                        end
                    end
            endcase
        end
    end

    // outputs
    always_comb begin
        en    = en_q;
        phase = ph_q;
        ccf   = ccf_q;
    end
endmodule

// File: rtl/cst_key_tracker.sv
module cst_key_tracker
    import cst_pkg::*;
#(
    parameter int KEY_MIN_WORDS = 4,
    parameter int KEY_MAX_WORDS = 8,
    parameter int KSEL_W        = 2
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             key_size,
    input  logic [KSEL_W-1:0]                key_sel,
    input  logic                             key_wr,
    input  logic [$clog2(KEY_MAX_WORDS)-1:0] key_idx,
    input  logic                             hw_key_done,
    input  logic                             hw_key_ok,
    input  logic                             keyerr_clr,
    output logic                             keyvalid,
    output logic                             keyerr,
    output logic                             hw_busy
);
    localparam int KIW = $clog2(KEY_MAX_WORDS);
    localparam int KCW = KIW + 1;

    kstate_e          st_q, st_d;
    logic [KCW-1:0]   cnt_q, cnt_d;
    logic             size_q;
    logic [KSEL_W-1:0] sel_q;

    logic [KCW-1:0] need, base, expect_idx;
    logic           cfg_chg, sw_wr, hw_src;

    assign need       = key_size ? KCW'(KEY_MAX_WORDS) : KCW'(KEY_MIN_WORDS);
    assign cfg_chg    = (key_size != size_q) || (key_sel != sel_q);
    assign hw_src     = (key_sel != '0);
    assign sw_wr      = key_wr && !hw_src;
    assign base       = (st_q == KS_COLLECT) ? cnt_q : '0;
    assign expect_idx = need - 1'b1 - base;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= KS_EMPTY;
            cnt_q  <= '0;
            size_q <= 1'b0;
            sel_q  <= '0;
        end else begin
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            size_q <= key_size;
            sel_q  <= key_sel;
        end
    end

    // next state
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            KS_FAULT:
                if (keyerr_clr) begin
                    st_d  = KS_EMPTY;
                    cnt_d = '0;
                end
            KS_HWLOAD:
                if (cfg_chg) begin
                    st_d = KS_EMPTY;
                end else if (hw_key_done) begin
                    st_d = hw_key_ok ? KS_READY : KS_FAULT;
                end
            KS_EMPTY, KS_COLLECT, KS_READY:
                if (cfg_chg) begin
                    st_d  = KS_EMPTY;
                    cnt_d = '0;
                end else if (hw_src && st_q == KS_EMPTY) begin
                    st_d = KS_HWLOAD;
                end else if (sw_wr) begin
                    if ({1'b0, key_idx} == expect_idx) begin
                        if (base + 1'b1 == need) begin
                            st_d  = KS_READY;
                            cnt_d = '0;
                        end else begin
                            st_d  = KS_COLLECT;
                            cnt_d = base + 1'b1;
                        end
                    end else begin
                        st_d  = KS_FAULT;
                        cnt_d = '0;
                    end
                end
            default: begin
                st_d  = KS_EMPTY;
                cnt_d = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        keyvalid = (st_q == KS_READY);
        keyerr   = (st_q == KS_FAULT);
        hw_busy  = (st_q == KS_HWLOAD);
    end
endmodule

// File: rtl/cst_access_monitor.sv
module cst_access_monitor
    import cst_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  phase_e        phase,
    input  logic          din_wr,
    input  logic [DW-1:0] din_wdata,
    input  logic          dout_rd,
    input  logic [DW-1:0] core_dout,
    input  logic          rwe_clr,
    input  logic          rwe_ie,
    output logic          din_fwd,
    output logic [DW-1:0] din_fdata,
    output logic [DW-1:0] dout_rdata,
    output logic          wrerr,
    output logic          rderr,
    output logic          irq
);
    logic bad_wr, bad_rd, wr_q, rd_q;

    assign bad_wr = din_wr  && (phase == PH_CRUNCH || phase == PH_DRAIN);
    assign bad_rd = dout_rd && (phase == PH_CRUNCH || phase == PH_LOAD);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q <= 1'b0;
            rd_q <= 1'b0;
        end else begin
            if (bad_wr)       wr_q <= 1'b1;
            else if (rwe_clr) wr_q <= 1'b0;
            if (bad_rd)       rd_q <= 1'b1;
            else if (rwe_clr) rd_q <= 1'b0;
        end
    end

    always_comb begin
        din_fwd    = din_wr && (phase == PH_LOAD);
        din_fdata  = din_fwd ? din_wdata : '0;
        dout_rdata = (phase == PH_DRAIN) ? core_dout : '0;
        wrerr      = wr_q;
        rderr      = rd_q;
        irq        = rwe_ie && (wr_q || rd_q);
    end
endmodule

// File: rtl/cipher_status_tracker.sv
module cipher_status_tracker
    import cst_pkg::*;
#(
    parameter int DW            = 32,
    parameter int BLK_WORDS     = 4,
    parameter int KEY_MIN_WORDS = 4,
    parameter int KEY_MAX_WORDS = 8,
    parameter int KSEL_W        = 2
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             en_set,
    input  logic                             en_clr,
    input  logic                             din_wr,
    input  logic [DW-1:0]                    din_wdata,
    output logic                             din_fwd,
    output logic [DW-1:0]                    din_fdata,
    input  logic                             dout_rd,
    input  logic [DW-1:0]                    core_dout,
    output logic [DW-1:0]                    dout_rdata,
    input  logic                             core_done,
    input  logic                             key_size,
    input  logic [KSEL_W-1:0]                key_sel,
    input  logic                             key_wr,
    input  logic [$clog2(KEY_MAX_WORDS)-1:0] key_idx,
    input  logic                             hw_key_done,
    input  logic                             hw_key_ok,
    input  logic                             keyerr_clr,
    input  logic                             rwe_clr,
    input  logic                             ccf_clr,
    input  logic                             rwe_ie,
    output logic                             en,
    output logic                             busy,
    output logic                             ccf,
    output logic                             wrerr,
    output logic                             rderr,
    output logic                             keyvalid,
    output logic                             keyerr,
    output logic                             irq
);
    phase_e phase;
    logic   hw_busy;

    cst_phase_ctrl #(.BLK_WORDS(BLK_WORDS)) u_phase (
        .clk(clk), .rst_n(rst_n), .en_set(en_set), .en_clr(en_clr),
        .keyvalid(keyvalid), .din_wr(din_wr), .dout_rd(dout_rd),
        .core_done(core_done), .ccf_clr(ccf_clr),
        .en(en), .phase(phase), .ccf(ccf)
    );

    cst_key_tracker #(
        .KEY_MIN_WORDS(KEY_MIN_WORDS), .KEY_MAX_WORDS(KEY_MAX_WORDS), .KSEL_W(KSEL_W)
    ) u_key (
        .clk(clk), .rst_n(rst_n), .key_size(key_size), .key_sel(key_sel),
        .key_wr(key_wr), .key_idx(key_idx), .hw_key_done(hw_key_done),
        .hw_key_ok(hw_key_ok), .keyerr_clr(keyerr_clr),
        .keyvalid(keyvalid), .keyerr(keyerr), .hw_busy(hw_busy)
    );

    cst_access_monitor #(.DW(DW)) u_acc (
        .clk(clk), .rst_n(rst_n), .phase(phase), .din_wr(din_wr),
        .din_wdata(din_wdata), .dout_rd(dout_rd), .core_dout(core_dout),
        .rwe_clr(rwe_clr), .rwe_ie(rwe_ie), .din_fwd(din_fwd),
        .din_fdata(din_fdata), .dout_rdata(dout_rdata),
        .wrerr(wrerr), .rderr(rderr), .irq(irq)
    );

    assign busy = hw_busy || (phase == PH_CRUNCH);
endmodule

// File: rtl/cipher_status_tracker_chk.sv
module cipher_status_tracker_chk
    import cst_pkg::*;
#(
    parameter int DW     = 32,
    parameter int KSEL_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input phase_e            phase,
    input logic              din_wr,
    input logic              din_fwd,
    input logic              dout_rd,
    input logic [DW-1:0]     dout_rdata,
    input logic              core_done,
    input logic              rwe_clr,
    input logic              rwe_ie,
    input logic [KSEL_W-1:0] key_sel,
    input logic              keyerr_clr,
    input logic              en,
    input logic              busy,
    input logic              ccf,
    input logic              wrerr,
    input logic              rderr,
    input logic              keyvalid,
    input logic              keyerr,
    input logic              irq
);
    p_wrerr_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        din_wr && (phase == PH_CRUNCH || phase == PH_DRAIN) |=> wrerr);

    p_no_fwd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_LOAD) |-> !din_fwd);

    p_rd_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dout_rd && (phase != PH_DRAIN) |-> dout_rdata == '0);

    p_crunch_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        phase == PH_CRUNCH && en && !core_done |=> phase == PH_CRUNCH);

    p_rwe_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rwe_clr && !din_wr && !dout_rd |=> !wrerr && !rderr);

    p_irq_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rwe_ie && $rose(wrerr) |-> irq);

    p_key_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(keyvalid && keyerr));

    p_keyerr_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        keyerr && !keyerr_clr |=> keyerr);

    p_hw_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(keyvalid) && key_sel != '0 |-> $past(busy));

    p_en_guard_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en) |-> $past(keyvalid));

    p_ccf_cause_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ccf) |-> $past(core_done));
endmodule

bind cipher_status_tracker cipher_status_tracker_chk #(.DW(DW), .KSEL_W(KSEL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .phase(phase), .din_wr(din_wr), .din_fwd(din_fwd),
    .dout_rd(dout_rd), .dout_rdata(dout_rdata), .core_done(core_done),
    .rwe_clr(rwe_clr), .rwe_ie(rwe_ie), .key_sel(key_sel), .keyerr_clr(keyerr_clr),
    .en(en), .busy(busy), .ccf(ccf), .wrerr(wrerr), .rderr(rderr),
    .keyvalid(keyvalid), .keyerr(keyerr), .irq(irq)
);

// File: tb/cipher_status_tracker_test.sv
module cipher_status_tracker_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en_set = 0, en_clr = 0, din_wr = 0, dout_rd = 0, core_done = 0;
    logic [31:0] din_wdata = '0, core_dout = '0;
    logic        key_size = 0, key_wr = 0, hw_key_done = 0, hw_key_ok = 0;
    logic [1:0]  key_sel = '0;
    logic [2:0]  key_idx = '0;
    logic        keyerr_clr = 0, rwe_clr = 0, ccf_clr = 0, rwe_ie = 0;
    logic        din_fwd, en, busy, ccf, wrerr, rderr, keyvalid, keyerr, irq;
    logic [31:0] din_fdata, dout_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    cipher_status_tracker uut (
        .clk(clk), .rst_n(rst_n), .en_set(en_set), .en_clr(en_clr),
        .din_wr(din_wr), .din_wdata(din_wdata), .din_fwd(din_fwd), .din_fdata(din_fdata),
        .dout_rd(dout_rd), .core_dout(core_dout), .dout_rdata(dout_rdata),
        .core_done(core_done), .key_size(key_size), .key_sel(key_sel),
        .key_wr(key_wr), .key_idx(key_idx), .hw_key_done(hw_key_done),
        .hw_key_ok(hw_key_ok), .keyerr_clr(keyerr_clr), .rwe_clr(rwe_clr),
        .ccf_clr(ccf_clr), .rwe_ie(rwe_ie), .en(en), .busy(busy), .ccf(ccf),
        .wrerr(wrerr), .rderr(rderr), .keyvalid(keyvalid), .keyerr(keyerr), .irq(irq)
    );

    // {size, count[3:0], idx list (first at [2:0]) [23:0], exp valid, exp err}
    localparam logic [30:0] VEC [6] = '{
        {1'b0, 4'd4, 24'o00000123, 1'b1, 1'b0},
        {1'b1, 4'd8, 24'o01234567, 1'b1, 1'b0},
        {1'b0, 4'd2, 24'o00000013, 1'b0, 1'b1},
        {1'b1, 4'd4, 24'o00000123, 1'b0, 1'b1},
        {1'b0, 4'd4, 24'o00003210, 1'b0, 1'b1},
        {1'b1, 4'd3, 24'o00000567, 1'b0, 1'b0}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic load_key(input logic sz, input int n, input logic [23:0] lst);
        keyerr_clr = 1; tick(); keyerr_clr = 0;
        key_size = ~sz; tick();
        key_size = sz;  tick();
        for (int k = 0; k < n; k++) begin
            key_wr = 1; key_idx = lst[3*k +: 3]; tick();
        end
        key_wr = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1;
        // R1 reset state
        chk({en, busy, ccf, wrerr, rderr, keyvalid, keyerr, irq} == 8'h00, "R1",
            {en, busy, ccf, wrerr, rderr, keyvalid, keyerr, irq}, 0);

        // R11 enable refused without key
        en_set = 1; tick(); en_set = 0;
        chk(en == 0, "R11 no key", en, 0);

        // R7 R8 table walk
        for (int v = 0; v < 6; v++) begin
            load_key(VEC[v][30], int'(VEC[v][29:26]), VEC[v][25:2]);
            chk(keyvalid == VEC[v][1], $sformatf("R7 vec%0d keyvalid", v), keyvalid, VEC[v][1]);
            chk(keyerr == VEC[v][0], $sformatf("R8 vec%0d keyerr", v), keyerr, VEC[v][0]);
        end

        // R9 sticky error ignores a correct sequence
        load_key(1'b0, 1, 24'o0);
        for (int k = 3; k >= 0; k--) begin
            key_wr = 1; key_idx = 3'(k); tick();
        end
        key_wr = 0;
        chk(keyerr == 1 && keyvalid == 0, "R9 sticky", {keyerr, keyvalid}, 2'b10);

        // valid key for the phase tests
        load_key(1'b0, 4, 24'o00000123);
        chk(keyvalid == 1, "R7 reload", keyvalid, 1);

        // R11 enable accepted
        en_set = 1; tick(); en_set = 0;
        chk(en == 1, "R11 enable", en, 1);
        tick();  // phase now input

        // R3 stray read in input phase
        dout_rd = 1; core_dout = 32'hA5A5_0001; #1;
        chk(dout_rdata == 0, "R3 rdata zero", dout_rdata, 0);
        tick(); dout_rd = 0;
        chk(rderr == 1, "R3 rderr", rderr, 1);

        // R12 R4 input writes
        for (int i = 0; i < 4; i++) begin
            din_wr = 1; din_wdata = 32'(100 + i); #1;
            chk(din_fwd == 1 && din_fdata == 32'(100 + i), "R12 forward", din_fdata, 32'(100 + i));
            tick();
            if (i == 2) chk(busy == 0, "R4 three writes", busy, 0);
        end
        din_wr = 0;
        chk(busy == 1, "R4 compute after four", busy, 1);

        // R6 R5 interrupt and clear
        rwe_ie = 1; #1;
        chk(irq == 1, "R6 irq on", irq, 1);
        rwe_clr = 1; tick(); rwe_clr = 0;
        chk(rderr == 0 && irq == 0, "R5 clear", {rderr, irq}, 0);

        // R2 stray write during computation
        din_wr = 1; din_wdata = 32'hDEAD_BEEF; #1;
        chk(din_fwd == 0 && din_fdata == 0, "R2 not forwarded", din_fdata, 0);
        tick(); din_wr = 0;
        chk(wrerr == 1, "R2 wrerr", wrerr, 1);
        chk(busy == 1, "R4 still computing", busy, 1);
        chk(irq == 1, "R6 irq wrerr", irq, 1);
        rwe_ie = 0; #1;
        chk(irq == 0, "R6 irq masked", irq, 0);

        // R12 completion and output
        core_done = 1; tick(); core_done = 0;
        chk(ccf == 1 && busy == 0, "R12 ccf", {ccf, busy}, 2'b10);
        for (int i = 0; i < 4; i++) begin
            dout_rd = 1; core_dout = 32'hC0DE_0000 + 32'(i); #1;
            chk(dout_rdata == 32'hC0DE_0000 + 32'(i), "R12 output", dout_rdata, 32'hC0DE_0000 + 32'(i));
            tick();
        end
        dout_rd = 0;
        din_wr = 1; din_wdata = 32'h55; #1;
        chk(din_fwd == 1, "R12 back to input", din_fwd, 1);
        tick(); din_wr = 0;
        ccf_clr = 1; tick(); ccf_clr = 0;
        chk(ccf == 0, "R12 ccf clear", ccf, 0);
        en_clr = 1; tick(); en_clr = 0;

        // R13 config change drops key
        key_size = 1; tick();
        chk(keyvalid == 0, "R13 size change", keyvalid, 0);

        // R10 hardware key: fail then succeed
        key_sel = 2'd1; tick(); tick();
        chk(busy == 1, "R10 busy", busy, 1);
        hw_key_done = 1; hw_key_ok = 0; tick(); hw_key_done = 0;
        chk(keyerr == 1 && busy == 0 && keyvalid == 0, "R10 fail", {keyerr, busy, keyvalid}, 3'b100);
        keyerr_clr = 1; tick(); keyerr_clr = 0; tick();
        chk(busy == 1, "R10 busy again", busy, 1);
        hw_key_done = 1; hw_key_ok = 1; tick(); hw_key_done = 0;
        chk(keyvalid == 1 && busy == 0, "R10 ok", {keyvalid, busy}, 2'b10);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule